// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a small synchronous static memory for use inside a larger design. A word is made of several 8-bit byte lanes. The address, the write data and every control input are captured on the rising clock edge. A write can update any set of byte lanes or the whole word. A read passes the array output through an output register, so read data appears one edge after the array access and two edges after the address was sampled.

The block uses three chip-select inputs so that several instances can share an address space: two are active low and one is active high. The registered select travels through a second, delay register, which lines it up with the read data leaving the output register. An asynchronous output-enable input then gates the result. In this pure-logic version, a valid flag replaces a high-impedance pad: when the flag is low, the data output is held at zero.

Any cycle that is selected and is not a write is a read. An external address generator supplies the address every cycle.

Top module: `pipe_bw_sram`

## Requirements
- R1: Address, write data, selects and write controls are sampled only at the rising clock edge. Changes between edges have no effect.
- R2: With `wr_all_n` high and `lane_wr_gate_n` low, bit i of `lane_wr_n` low writes byte lane i, meaning bits [8i+7:8i] of `wdata`. All other lanes of the addressed word keep their contents.
- R3: With `wr_all_n` low, every byte lane of the addressed word is written, whatever `lane_wr_n` and `lane_wr_gate_n` hold.
- R4: With `wr_all_n` high and `lane_wr_gate_n` high, `lane_wr_n` has no effect. The cycle is a read and the memory is unchanged.
- R5: The block is selected only when `cs0_n` is 0, `cs1` is 1 and `cs2_n` is 0. An unselected cycle writes nothing, and `rdata_vld` is low two edges later.
- R6: A selected read sampled at edge N gives `rdata_vld` high and `rdata` equal to the stored word after edge N+1.
- R7: While `oe_n` is high, `rdata_vld` is 0 and `rdata` is 0, with no clock edge needed.
- R8: A write at edge N, followed by a read of the same address at edge N+1, returns the newly written lanes merged with the lanes left unchanged.
- R9: While `rst_n` is low at a clock edge, the pipeline clears, so `rdata_vld` and `rdata` are 0. Memory contents are not cleared.
- R10: A selected write cycle never drives the output: `rdata_vld` is low two edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline |
| addr | input | AW | Word address |
| wdata | input | LANES*8 | Write data, lane i in bits [8i+7:8i] |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| lane_wr_gate_n | input | 1 | Qualifier for per-lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| rdata | output | LANES*8 | Read data, zero when not valid |
| rdata_vld | output | 1 | Read data is being driven |

## Verification
On every cycle, the assertions check three things against the pins as seen two edges earlier: `rdata_vld` rises only for a selected non-write cycle, and stays low after unselected or write cycles. They also check that a registered lane mask exists only for a selected, write-qualified cycle, and that a whole-word write always produces a full mask. Whether the right bytes land in the array can be seen only through the bench's scenarios. The same holds for lane merging on a write followed by a read, for the ignored lane enables when the qualifier is high, and for the asynchronous effect of `oe_n`. In those scenarios a behavioural memory model is compared against the outputs on every clock.

// File: rtl/pbs_pkg.sv
// Shared constants for the pipelined byte-write SRAM.
// Assumes byte lanes are always 8 bits wide.
package pbs_pkg;
    localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/pbs_in_stage.sv
// Input register stage: samples address, data, decoded select and the
// per-lane write mask on the rising edge.
// Assumes the active-low write controls arrive straight from the pins.
module pbs_in_stage #(
    parameter int unsigned AW    = 4,
    parameter int unsigned LANES = 4,
    localparam int unsigned DW   = LANES * pbs_pkg::LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             sel_i,
    input  logic             wr_all_n_i,
    input  logic             gate_n_i,
    input  logic [LANES-1:0] lane_n_i,
    output logic [AW-1:0]    addr_q,
    output logic [DW-1:0]    wdata_q,
    output logic             sel_q,
    output logic [LANES-1:0] mask_q
);
    logic [LANES-1:0] lane_en;

    // Per-lane write decode: the global write overrides the gated lane enables.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g] = !wr_all_n_i || (!gate_n_i && !lane_n_i[g]);
    end

    // Capture every input on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            sel_q   <= 1'b0;
            mask_q  <= '0;
        end else begin
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            sel_q   <= sel_i;
            mask_q  <= sel_i ? lane_en : '0;
        end
    end

    p_mask_needs_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|mask_q) |-> ($past(sel_i) && $past(rst_n)));

    p_mask_needs_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|mask_q) |-> ($past(!wr_all_n_i) || $past(!gate_n_i)));

    p_global_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_i && !wr_all_n_i)) |-> (&mask_q));
endmodule

// File: rtl/pbs_array.sv
// Byte-laned storage: one byte memory per lane, written under the
// registered mask, read combinationally at the registered address.
// Assumes contents are not reset.
module pbs_array #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LANES = 4,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned DW   = LANES * pbs_pkg::LANE_W
) (
    input  logic             clk,
    input  logic [AW-1:0]    addr_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [LANES-1:0] mask_i,
    output logic [DW-1:0]    rdata_o
);
    localparam int unsigned LW = pbs_pkg::LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        // Write this lane's byte when its mask bit is set.
        always_ff @(posedge clk) begin
            if (mask_i[g]) mem[addr_i] <= wdata_i[g*LW +: LW];
        end

        assign rdata_o[g*LW +: LW] = mem[addr_i];
    end
endmodule

// File: rtl/pbs_out_stage.sv
// Output stage: registers the array word on reads, delays the select so
// it lines up with that word, and gates both with the output enable.
// Assumes oe_n is asynchronous to the clock.
module pbs_out_stage #(
    parameter int unsigned LANES = 4,
    localparam int unsigned DW   = LANES * pbs_pkg::LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    arr_i,
    input  logic             sel_q_i,
    input  logic [LANES-1:0] mask_q_i,
    input  logic             oe_n_i,
    output logic [DW-1:0]    rdata_o,
    output logic             vld_o
);
    logic          rd_cycle;
    logic          en_dly;
    logic [DW-1:0] out_q;

    assign rd_cycle = sel_q_i && (mask_q_i == '0);

    // Output register and enable-delay register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            en_dly <= 1'b0;
        end else begin
            en_dly <= rd_cycle;
            if (rd_cycle) out_q <= arr_i;
        end
    end

    assign vld_o   = en_dly && !oe_n_i;
    assign rdata_o = vld_o ? out_q : '0;
endmodule

// File: rtl/pipe_bw_sram.sv
// Pipelined byte-write synchronous SRAM top: select decode, input
// registers, byte-laned array and registered output.
// Assumes an external generator drives addr every cycle.
module pipe_bw_sram #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LANES = 4,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned DW   = LANES * pbs_pkg::LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic             cs0_n,
    input  logic             cs1,
    input  logic             cs2_n,
    input  logic             wr_all_n,
    input  logic             lane_wr_gate_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             oe_n,
    output logic [DW-1:0]    rdata,
    output logic             rdata_vld
);
    logic             sel;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    wdata_q;
    logic             sel_q;
    logic [LANES-1:0] mask_q;
    logic [DW-1:0]    arr_rd;
    logic             wr_req;

    assign sel    = !cs0_n && cs1 && !cs2_n;
    assign wr_req = !wr_all_n || (!lane_wr_gate_n && !(&lane_wr_n));

    pbs_in_stage #(.AW(AW), .LANES(LANES)) u_in (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .sel_i(sel),
        .wr_all_n_i(wr_all_n), .gate_n_i(lane_wr_gate_n), .lane_n_i(lane_wr_n),
        .addr_q(addr_q), .wdata_q(wdata_q), .sel_q(sel_q), .mask_q(mask_q)
    );

    pbs_array #(.DEPTH(DEPTH), .LANES(LANES)) u_arr (
        .clk(clk), .addr_i(addr_q), .wdata_i(wdata_q), .mask_i(mask_q),
        .rdata_o(arr_rd)
    );

    pbs_out_stage #(.LANES(LANES)) u_out (
        .clk(clk), .rst_n(rst_n), .arr_i(arr_rd), .sel_q_i(sel_q),
        .mask_q_i(mask_q), .oe_n_i(oe_n), .rdata_o(rdata), .vld_o(rdata_vld)
    );

    p_vld_from_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_vld |-> ($past(sel && !wr_req, 2) && $past(rst_n, 2)));

    p_unsel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sel, 2) |-> !rdata_vld);

    p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && wr_req, 2) |-> !rdata_vld);
endmodule

// File: tb/pipe_bw_sram_bench.sv
module pipe_bw_sram_bench;
    localparam int DEPTH = 16;
    localparam int LANES = 4;
    localparam int AW = 4;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
    logic wr_all_n = 1'b1, lane_wr_gate_n = 1'b1;
    logic [LANES-1:0] lane_wr_n = '1;
    logic oe_n = 1'b0;
    logic [DW-1:0] rdata;
    logic rdata_vld;

    int n_run = 0;
    int n_fail = 0;
    string cur_req = "R9";

    // Reference model state.
    logic [DW-1:0] ref_mem [DEPTH];
    bit            s_sel, s_rd;
    logic [3:0]    s_mask;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;
    bit            o_en;
    logic [DW-1:0] o_word;

    always #4 clk = ~clk;

    pipe_bw_sram u_pipe_bw_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .wr_all_n(wr_all_n),
        .lane_wr_gate_n(lane_wr_gate_n), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    task automatic compare();
        bit exp_v;
        logic [DW-1:0] exp_d;
        exp_v = o_en && !oe_n;
        exp_d = exp_v ? o_word : '0;
        n_run++;
        if (rdata_vld !== exp_v || rdata !== exp_d) begin
            n_fail++;
            $display("FAIL %s: vld=%0b data=%h expected vld=%0b data=%h",
                     cur_req, rdata_vld, rdata, exp_v, exp_d);
        end
    endtask

    // One clock: update the model at the edge, compare just after it.
    task automatic step();
        bit sel_now;
        logic [3:0] m;
        @(posedge clk);
        if (!rst_n) begin
            s_sel = 0; s_rd = 0; s_mask = 0; o_en = 0; o_word = '0;
        end else begin
            for (int i = 0; i < LANES; i++)
                if (s_mask[i]) ref_mem[s_addr][i*8 +: 8] = s_data[i*8 +: 8];
            o_en = s_rd;
            if (s_rd) o_word = ref_mem[s_addr];
            sel_now = !cs0_n && cs1 && !cs2_n;
            if (!wr_all_n) m = 4'hF;
            else if (!lane_wr_gate_n) m = ~lane_wr_n;
            else m = 4'h0;
            s_sel  = sel_now;
            s_mask = sel_now ? m : 4'h0;
            s_rd   = sel_now && (m == 4'h0);
            s_addr = addr;
            s_data = wdata;
        end
        #1 compare();
        @(negedge clk);
    endtask

    task automatic drive(input bit sel, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit gw_n, input bit gate_n, input logic [3:0] ln_n);
        cs0_n = !sel; cs1 = sel; cs2_n = !sel;
        addr = a; wdata = d; wr_all_n = gw_n; lane_wr_gate_n = gate_n; lane_wr_n = ln_n;
        step();
    endtask

    task automatic rd(input logic [AW-1:0] a);
        drive(1, a, 32'hDEAD_BEEF, 1, 1, 4'hF);
    endtask

    task automatic idle();
        drive(0, '0, '0, 1, 1, 4'hF);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R9: reset state while reset is held with a read request present.
        cur_req = "R9";
        rst_n = 1'b0;
        cs0_n = 0; cs1 = 1; cs2_n = 0;
        for (int i = 0; i < 3; i++) step();
        rst_n = 1'b1;
        // R3: whole-word writes fill the array, lane enables set to "none".
        cur_req = "R3";
        for (int i = 0; i < DEPTH; i++) drive(1, i[AW-1:0], 32'h1000_0000 + i * 32'h0101_0101, 0, 1, 4'hF);
        idle(); idle();
        // R6 and R1: reads of several addresses, two-edge latency.
        cur_req = "R6";
        for (int i = 0; i < DEPTH; i += 3) rd(i[AW-1:0]);
        idle(); idle();
        // R1: inputs changed between edges have no effect until the edge.
        cur_req = "R1";
        addr = 4'd5; cs0_n = 0; cs1 = 1; cs2_n = 0; wr_all_n = 1; lane_wr_gate_n = 1;
        #1 addr = 4'd9; wr_all_n = 0; #1 wr_all_n = 1;
        step(); idle(); idle();
        // R2 and R8: lane writes followed at once by a read of the same word.
        cur_req = "R8";
        drive(1, 4'd2, 32'hAABB_CCDD, 1, 0, 4'b1110); rd(4'd2);
        drive(1, 4'd3, 32'h1122_3344, 1, 0, 4'b0101); rd(4'd3);
        drive(1, 4'd4, 32'h5566_7788, 1, 0, 4'b0110); rd(4'd4);
        idle(); idle();
        cur_req = "R2";
        rd(4'd2); rd(4'd3); rd(4'd4); idle(); idle();
        // R3: global write overrides lane enables and an inactive qualifier.
        cur_req = "R3";
        drive(1, 4'd6, 32'hCAFE_F00D, 0, 1, 4'b1111); rd(4'd6);
        drive(1, 4'd7, 32'h0BAD_0BAD, 0, 0, 4'b1010); rd(4'd7);
        idle(); idle();
        // R4: lane enables ignored with qualifier high: read, memory unchanged.
        cur_req = "R4";
        drive(1, 4'd8, 32'hFFFF_FFFF, 1, 1, 4'b0000); rd(4'd8); idle(); idle();
        // R5: each select deasserted alone blocks the write and the output.
        cur_req = "R5";
        for (int k = 0; k < 3; k++) begin
            cs0_n = (k == 0); cs1 = (k != 1); cs2_n = (k == 2);
            addr = 4'd9; wdata = 32'h7777_7777; wr_all_n = 0; step();
            wr_all_n = 1; step();
        end
        idle(); idle(); rd(4'd9); idle(); idle();
        // R7: output enable high masks a valid read, then releases it.
        cur_req = "R7";
        oe_n = 1; rd(4'd10); idle();
        oe_n = 0; #1 compare();
        idle();
        oe_n = 1; rd(4'd11); rd(4'd12); #1 compare(); oe_n = 0; #1 compare();
        idle(); idle();
        // R10: back-to-back writes never raise the valid flag.
        cur_req = "R10";
        drive(1, 4'd13, 32'h1, 0, 1, 4'hF);
        drive(1, 4'd14, 32'h2, 1, 0, 4'b0011);
        drive(1, 4'd15, 32'h3, 0, 0, 4'hF);
        idle(); idle();
        // R9: mid-run reset clears the pipeline but not the memory.
        cur_req = "R9";
        rd(4'd14); rst_n = 0; step(); rst_n = 1; idle(); idle();
        rd(4'd14); idle(); idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule